// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block keeps the sixteen-bit normal interrupt status word for one channel of an SD/MMC host controller and produces that channel's interrupt request. The controller core feeds it single-cycle event pulses for command done, transfer done and read wait. It also feeds a card interrupt level, the error status vector and the SD-side FIFO pointer. The unit holds four programmable pointer thresholds. When the pointer arrives at one of them, the status bit that belongs to that threshold is raised.

Software sees three registers. The first is the status word, which it clears by writing ones. The second is a status-enable mask, which decides which events may latch and which bits a read returns. The third is a signal-enable mask, which decides which visible bits may raise the interrupt output. The card interrupt bit and the error summary bit are mirrors of their sources and cannot be cleared by writes.

Top module: `sd_irq_status_unit`

## Requirements
- R1: After reset, every status bit reads 0, all masks and thresholds are 0, and irq_o is 0.
- R2: sts_rd_o equals the status word ANDed with the status-enable mask. The signal-enable mask has no effect on what sts_rd_o returns.
- R3: A clear write with a 1 in bit 0, 1, 10, 11, 12, 13 or 14 clears that bit on the next clock. A 0 in the written data leaves the bit unchanged. Several bits can be cleared by one write.
- R4: Bit 15 is 1 one clock after any bit of err_bits_i is 1, and 0 one clock after all of them are 0. Clear writes do not change it.
- R5: Bit 8 follows card_irq_i with one clock of delay. Clear writes do not change it.
- R6: Threshold k (thr_sel_i = k, for k = 0..3) maps to status bit 11+k. That bit is set one clock after fifo_ptr_i first equals the threshold.
- R7: A pointer that stays equal to a threshold sets its bit only once. After a clear, the bit stays 0 until the pointer has left the threshold and come back to it.
- R8: An event sets its latched bit only if the matching status-enable bit is 1. If an event and a clear write of the same bit arrive in the same cycle, the bit ends up set.
- R9: Bit 0 is command done, bit 1 is transfer done and bit 10 is read wait. Bits 2 to 7 and bit 9 always read 0.
- R10: irq_o is registered. It is 1 exactly one clock after some bit of (status AND status-enable AND signal-enable) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_done_i | input | 1 | Command done event pulse |
| xfer_done_i | input | 1 | Transfer done event pulse |
| rd_wait_i | input | 1 | Read wait event pulse |
| card_irq_i | input | 1 | Card interrupt level |
| err_bits_i | input | ERR_W | Error status register contents |
| fifo_ptr_i | input | PTR_W | SD-side FIFO address pointer |
| thr_wr_i | input | 1 | Threshold write strobe |
| thr_sel_i | input | 2 | Threshold index for the write |
| thr_data_i | input | PTR_W | Threshold write value |
| sts_en_wr_i | input | 1 | Status-enable mask write strobe |
| sts_en_data_i | input | 16 | Status-enable mask value |
| sig_en_wr_i | input | 1 | Signal-enable mask write strobe |
| sig_en_data_i | input | 16 | Signal-enable mask value |
| clr_wr_i | input | 1 | Status clear write strobe |
| clr_data_i | input | 16 | Write-one-to-clear data |
| sts_rd_o | output | 16 | Status word as seen by a read |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a FIFO threshold bit after it has been cleared while the pointer still sits on the threshold. To reach it, the stimulus parks the pointer on the threshold, clears the bit, and holds it there for further cycles to show that the bit stays 0. It then steps the pointer away and back to show that the bit is raised again. The second hard case is an event and a clear of the same bit in the same cycle. The stimulus builds it by driving both in one low phase, and it also drives an event while that bit's enable is off. The bench then restores the enable and reads the state, which proves that nothing was latched.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;
    localparam int STS_W      = 16;
    localparam int N_FIA      = 4;
    localparam int BIT_CMD    = 0;
    localparam int BIT_XFER   = 1;
    localparam int BIT_CARD   = 8;
    localparam int BIT_RDWAIT = 10;
    localparam int BIT_FIA0   = 11;
    localparam int BIT_ERR    = 15;

    typedef logic [STS_W-1:0] sts_t;

    // bits that latch events and clear on a written 1
    function automatic sts_t latch_mask();
        sts_t m;
        m = '0;
        m[BIT_CMD]    = 1'b1;
        m[BIT_XFER]   = 1'b1;
        m[BIT_RDWAIT] = 1'b1;
        for (int k = 0; k < N_FIA; k++) m[BIT_FIA0+k] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/sd_irq_fifo_match.sv
module sd_irq_fifo_match #(
    parameter int PTR_W = 8,
    parameter int N_THR = 4,
    parameter int SEL_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_wr_i,
    input  logic [SEL_W-1:0] thr_sel_i,
    input  logic [PTR_W-1:0] thr_data_i,
    input  logic [PTR_W-1:0] fifo_ptr_i,
    output logic [N_THR-1:0] hit_pulse_o
);
    typedef struct packed {
        logic [N_THR-1:0][PTR_W-1:0] thr;
        logic [N_THR-1:0]            hit;
    } fm_state_t;

    fm_state_t st_d, st_q;
    logic [N_THR-1:0] hit_now;

    genvar g;
    generate
        for (g = 0; g < N_THR; g++) begin : g_cmp
            assign hit_now[g] = (fifo_ptr_i == st_q.thr[g]);
        end
    endgenerate

    assign hit_pulse_o = hit_now & ~st_q.hit;

    always_comb begin
        st_d     = st_q;
        st_d.hit = hit_now;
        for (int k = 0; k < N_THR; k++) begin
            if (thr_wr_i && (int'(thr_sel_i) == k)) st_d.thr[k] = thr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (g = 0; g < N_THR; g++) begin : g_chk
            // R7: one pulse per arrival at a threshold
            a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
                hit_pulse_o[g] |=> !hit_pulse_o[g]);
        end
    endgenerate
endmodule

// File: rtl/sd_irq_status_reg.sv
module sd_irq_status_reg
    import sd_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sts_t sts_en_i,
    input  sts_t set_i,
    input  logic card_i,
    input  logic err_any_i,
    input  logic clr_wr_i,
    input  sts_t clr_data_i,
    output sts_t status_o
);
    localparam sts_t LMASK = latch_mask();

    typedef struct packed {
        sts_t sts;
    } sr_state_t;

    sr_state_t st_d, st_q;
    sts_t      clr_vec;

    always_comb begin
        clr_vec     = clr_wr_i ? clr_data_i : '0;
        st_d        = st_q;
        st_d.sts    = ((st_q.sts & ~clr_vec) | (set_i & sts_en_i)) & LMASK;
        st_d.sts[BIT_CARD] = card_i;
        st_d.sts[BIT_ERR]  = err_any_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.sts;

    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && clr_data_i[BIT_XFER] && !set_i[BIT_XFER]) |=> !status_o[BIT_XFER]);
    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr_i && status_o[BIT_CMD]) |=> status_o[BIT_CMD]);
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i[BIT_CMD] && sts_en_i[BIT_CMD]) |=> status_o[BIT_CMD]);
    a_r8_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[BIT_RDWAIT] && !sts_en_i[BIT_RDWAIT]) |=> !status_o[BIT_RDWAIT]);
    a_r4_err_summary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_any_i) |=> status_o[BIT_ERR]);
    a_r5_card_level: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_i) |=> !status_o[BIT_CARD]);
endmodule

// File: rtl/sd_irq_status_unit.sv
module sd_irq_status_unit
    import sd_irq_pkg::*;
#(
    parameter int PTR_W = 8,
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_done_i,
    input  logic             xfer_done_i,
    input  logic             rd_wait_i,
    input  logic             card_irq_i,
    input  logic [ERR_W-1:0] err_bits_i,
    input  logic [PTR_W-1:0] fifo_ptr_i,
    input  logic             thr_wr_i,
    input  logic [1:0]       thr_sel_i,
    input  logic [PTR_W-1:0] thr_data_i,
    input  logic             sts_en_wr_i,
    input  logic [15:0]      sts_en_data_i,
    input  logic             sig_en_wr_i,
    input  logic [15:0]      sig_en_data_i,
    input  logic             clr_wr_i,
    input  logic [15:0]      clr_data_i,
    output logic [15:0]      sts_rd_o,
    output logic             irq_o
);
    typedef struct packed {
        sts_t sts_en;
        sts_t sig_en;
        logic irq;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic [N_FIA-1:0]  hit_pulse;
    sts_t              set_vec;
    sts_t              status;

    sd_irq_fifo_match #(.PTR_W(PTR_W), .N_THR(N_FIA), .SEL_W(2)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .thr_wr_i    (thr_wr_i),
        .thr_sel_i   (thr_sel_i),
        .thr_data_i  (thr_data_i),
        .fifo_ptr_i  (fifo_ptr_i),
        .hit_pulse_o (hit_pulse)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[BIT_CMD]    = cmd_done_i;
        set_vec[BIT_XFER]   = xfer_done_i;
        set_vec[BIT_RDWAIT] = rd_wait_i;
        for (int k = 0; k < N_FIA; k++) set_vec[BIT_FIA0+k] = hit_pulse[k];
    end

    sd_irq_status_reg u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .sts_en_i   (st_q.sts_en),
        .set_i      (set_vec),
        .card_i     (card_irq_i),
        .err_any_i  (|err_bits_i),
        .clr_wr_i   (clr_wr_i),
        .clr_data_i (clr_data_i),
        .status_o   (status)
    );

    assign sts_rd_o = status & st_q.sts_en;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(sts_rd_o & st_q.sig_en);
        if (sts_en_wr_i) st_d.sts_en = sts_en_data_i;
        if (sig_en_wr_i) st_d.sig_en = sig_en_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    // R10: a request needs a visible source one clock earlier
    a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(sts_rd_o) != '0));
    // R2: a bit masked off in the status-enable never reads back
    a_r2_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_en_wr_i && !sts_en_data_i[BIT_CARD]) |=> !sts_rd_o[BIT_CARD]);
endmodule

// File: tb/tb_sd_irq_status_unit.sv
module tb_sd_irq_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_done_i = 0, xfer_done_i = 0, rd_wait_i = 0, card_irq_i = 0;
    logic [15:0] err_bits_i = '0;
    logic [7:0]  fifo_ptr_i = 8'hAA;
    logic        thr_wr_i = 0;
    logic [1:0]  thr_sel_i = '0;
    logic [7:0]  thr_data_i = '0;
    logic        sts_en_wr_i = 0, sig_en_wr_i = 0, clr_wr_i = 0;
    logic [15:0] sts_en_data_i = '0, sig_en_data_i = '0, clr_data_i = '0;
    logic [15:0] sts_rd_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sd_irq_status_unit dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_done_i(cmd_done_i), .xfer_done_i(xfer_done_i), .rd_wait_i(rd_wait_i),
        .card_irq_i(card_irq_i), .err_bits_i(err_bits_i), .fifo_ptr_i(fifo_ptr_i),
        .thr_wr_i(thr_wr_i), .thr_sel_i(thr_sel_i), .thr_data_i(thr_data_i),
        .sts_en_wr_i(sts_en_wr_i), .sts_en_data_i(sts_en_data_i),
        .sig_en_wr_i(sig_en_wr_i), .sig_en_data_i(sig_en_data_i),
        .clr_wr_i(clr_wr_i), .clr_data_i(clr_data_i),
        .sts_rd_o(sts_rd_o), .irq_o(irq_o)
    );

    typedef struct {
        logic [15:0] sts;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;

    // monitor: compares one expected item per falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            checks++;
            if (sts_rd_o !== cur.sts || irq_o !== cur.irq) begin
                failures++;
                $display("FAIL %s: sts=%h irq=%b expected sts=%h irq=%b",
                         cur.tag, sts_rd_o, irq_o, cur.sts, cur.irq);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic step_chk(input logic [15:0] s, input logic i, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        e.sts = s; e.irq = i; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic clear_strobes();
        cmd_done_i = 0; xfer_done_i = 0; rd_wait_i = 0;
        thr_wr_i = 0; sts_en_wr_i = 0; sig_en_wr_i = 0; clr_wr_i = 0;
    endtask

    task automatic clr(input logic [15:0] v);
        clr_wr_i = 1; clr_data_i = v;
    endtask

    task automatic set_thr(input logic [1:0] k, input logic [7:0] v);
        thr_wr_i = 1; thr_sel_i = k; thr_data_i = v;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: sts=%h irq=%b expected run to finish", sts_rd_o, irq_o);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step_chk(16'h0000, 0, "R1 reset state");

        sts_en_wr_i = 1; sts_en_data_i = 16'hFFFF;
        step();

        // R9 bit map: command done bit 0, transfer done bit 1
        cmd_done_i = 1; xfer_done_i = 1;
        step_chk(16'h0003, 0, "R9 cmd/xfer bits");

        // R2 read masking by status-enable
        sts_en_wr_i = 1; sts_en_data_i = 16'h0001;
        step_chk(16'h0001, 0, "R2 masked read");
        sts_en_wr_i = 1; sts_en_data_i = 16'hFFFF;
        step_chk(16'h0003, 0, "R2 unmasked read");

        // R3 write-one-to-clear
        clr(16'h0001);
        step_chk(16'h0002, 0, "R3 clear bit0");
        clr(16'h0000);
        step_chk(16'h0002, 0, "R3 zero write keeps");
        rd_wait_i = 1;
        step_chk(16'h0402, 0, "R9 read wait bit10");
        cmd_done_i = 1;
        step_chk(16'h0403, 0, "R9 cmd again");
        clr(16'h0403);
        step_chk(16'h0000, 0, "R3 multi clear");

        // R8 gating and event-wins
        sts_en_wr_i = 1; sts_en_data_i = 16'hFFFE;
        step_chk(16'h0000, 0, "R8 mask write");
        cmd_done_i = 1;
        step_chk(16'h0000, 0, "R8 event while disabled");
        sts_en_wr_i = 1; sts_en_data_i = 16'hFFFF;
        step_chk(16'h0000, 0, "R8 nothing latched");
        cmd_done_i = 1; clr(16'h0001);
        step_chk(16'h0001, 0, "R8 event beats clear");

        // R10 registered interrupt
        sig_en_wr_i = 1; sig_en_data_i = 16'h0001;
        step_chk(16'h0001, 0, "R10 irq not yet");
        step_chk(16'h0001, 1, "R10 irq asserted");
        clr(16'h0001);
        step_chk(16'h0000, 1, "R10 irq lags clear");
        step_chk(16'h0000, 0, "R10 irq dropped");

        // R5 card level
        card_irq_i = 1;
        step_chk(16'h0100, 0, "R5 card set");
        clr(16'h0100);
        step_chk(16'h0100, 0, "R5 clear ignored");
        card_irq_i = 0;
        step_chk(16'h0000, 0, "R5 card released");

        // R4 error summary
        err_bits_i = 16'h0004;
        step_chk(16'h8000, 0, "R4 error summary set");
        clr(16'h8000);
        step_chk(16'h8000, 0, "R4 clear ignored");
        err_bits_i = 16'h0000;
        step_chk(16'h0000, 0, "R4 error summary cleared");

        // R6 / R7 FIFO thresholds
        set_thr(2'd2, 8'h10);
        step_chk(16'h0000, 0, "R6 threshold written");
        fifo_ptr_i = 8'h10;
        step_chk(16'h2000, 0, "R6 thr2 to bit13");
        clr(16'h2000);
        step_chk(16'h0000, 0, "R7 cleared while equal");
        step_chk(16'h0000, 0, "R7 no re-set while equal");
        fifo_ptr_i = 8'h11;
        step_chk(16'h0000, 0, "R7 pointer left");
        fifo_ptr_i = 8'h10;
        step_chk(16'h2000, 0, "R7 re-arrival sets");
        clr(16'h2000);
        step_chk(16'h0000, 0, "R3 clear fifo bit");
        set_thr(2'd0, 8'h20);
        step();
        set_thr(2'd1, 8'h30);
        step();
        set_thr(2'd3, 8'h40);
        step();
        fifo_ptr_i = 8'h40;
        step_chk(16'h4000, 0, "R6 thr3 to bit14");
        fifo_ptr_i = 8'h20;
        step_chk(16'h4800, 0, "R6 thr0 to bit11");
        fifo_ptr_i = 8'h30;
        step_chk(16'h5800, 0, "R6 thr1 to bit12");
        clr(16'h5800);
        step_chk(16'h0000, 0, "R3 clear three fifo bits");

        // R2 signal-enable has no effect on reads
        sig_en_wr_i = 1; sig_en_data_i = 16'hFFFF; xfer_done_i = 1;
        step_chk(16'h0002, 0, "R2 sig-en write");
        step_chk(16'h0002, 1, "R10 irq via bit1");
        sig_en_wr_i = 1; sig_en_data_i = 16'h0000;
        step_chk(16'h0002, 1, "R2 read unchanged by sig-en");
        step_chk(16'h0002, 0, "R10 irq off with sig-en 0");

        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule